// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a set of external interrupt request pins, twenty-eight by default. Each pin first goes through a two-flop synchroniser. A per-line detector then looks for the trigger condition picked for that line: rising edge, falling edge, either edge, low level or high level. When the condition holds, the detector sets a sticky pending flag. Software clears pending flags by writing ones to them. Software can also mask each line separately. A masked line still records its events, but it cannot drive an interrupt output.

The block combines the requests that are pending and unmasked into four group outputs, which go to a parent interrupt controller. Group 0 covers lines 0-3, group 1 covers lines 4-11, group 2 covers lines 12-19 and group 3 covers lines 20-27. When a group output fires, software reads the request register. It then services the set bits in ascending line order and clears each bit it has handled.

Lines share trigger fields in pairs, so lines 2k and 2k+1 always use the same trigger type. The fields are packed four bits apart across two trigger registers.

Top module: `xirq_line_ctrl`

## Requirements
- R1: While reset is held, and right after it, every trigger register reads 0, the mask register reads 0x0FFFFFFF (all 28 lines masked), and the pending register, the request register and `irq_grp_o` are all 0.
- R2: Register addresses are fixed: 0 is trigger-low (lines 0-15), 1 is trigger-high (lines 16-27), 2 is mask, 3 is pending and 4 is request. The 3-bit field shared by lines n and n^1 sits at bit 4*((n mod 16)/2) of register n/16. Bit 3 of every nibble reads 0. Trigger-high nibbles 6 and 7 describe nonexistent lines 28-31: writes to them are ignored and they read 0.
- R3: Field encoding 3'b10x selects rising edge. A 0-to-1 pin change driven before clock edge k shows as pending after edge k+2 and not earlier. A falling edge on such a line sets nothing.
- R4: Field encoding 3'b01x selects falling edge. A 1-to-0 pin change sets pending with the same latency as R3. A rising edge on such a line sets nothing.
- R5: Field encoding 3'b11x selects both edges. Each pin change, in either direction, sets pending.
- R6: Field encoding 3'b001 selects high level and 3'b000 selects low level. Pending is set again on every cycle the active level is present. A clear therefore takes effect only once the level has gone away.
- R7: Writing the pending register clears each bit written as 1. Bits written as 0 keep their value.
- R8: When a set condition and a clear hit the same line in the same cycle, the pending bit stays 1.
- R9: Mask bit n = 1 keeps line n off its group output, but line n still records pending events. Mask bits 28-31 read 0 and ignore writes.
- R10: `irq_grp_o[g]` is 1 exactly when some line in group g is both pending and unmasked. Group 0 holds lines 0-3, group 1 lines 4-11, group 2 lines 12-19 and group 3 lines 20-27.
- R11: The request register (address 4) reads pending AND NOT mask. Its bits 28-31 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 28 | Asynchronous interrupt request pins |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_grp_o | output | 4 | Grouped requests to the parent controller |

## Verification
The bench sweeps all 28 lines in each edge mode, so a slip in the pair-to-nibble mapping or in the uneven group boundaries shows up as a set bit on the wrong line or the wrong group output. It checks the pending bit one cycle before it is due and again when it is due, so a synchroniser that is too short or too long fails the check. For level mode it clears a line while the level is still held and expects the bit to reappear, which catches a design where the clear beats the set. Further checks cover the following:
- a masked line must still latch its event;
- a write of zeros to pending must leave other lines untouched;
- writes to the nibbles and mask bits of nonexistent lines must not stick.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   localparam int unsigned TRIG_W = 3;
   localparam int unsigned NIB_W  = 4;

   // Trigger field: 000 low level, 001 high level, 01x fall, 10x rise, 11x any edge
   function automatic logic trig_hit(input logic [TRIG_W-1:0] mode,
                                     input logic cur, input logic prev);
      logic hit;
      unique case (mode[2:1])
         2'b00:   hit = mode[0] ? cur : ~cur;
         2'b01:   hit = ~cur & prev;
         2'b10:   hit = cur & ~prev;
         default: hit = cur ^ prev;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/xirq_line.sv
module xirq_line
   import xirq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic [TRIG_W-1:0] mode_i,
   input  logic              clr_i,
   output logic              pend_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xirq_line: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic                   hit;
   logic                   pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         prev_q <= cur;
      end
   end

   assign cur = sync_q[SYNC_STAGES-1];
   assign hit = trig_hit(mode_i, cur, prev_q);

   // set has priority over a clear arriving in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (hit)    pend_q <= 1'b1;
      else if (clr_i)  pend_q <= 1'b0;
   end

   assign pend_o = pend_q;

   // R8
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> pend_q);

   // R7
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> $past(clr_i));

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 28,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [DATA_W-1:0]                 wdata_i,
   input  logic [NUM_LINES-1:0]              pend_i,
   output logic [DATA_W-1:0]                 rdata_o,
   output logic [NUM_LINES-1:0]              mask_o,
   output logic [NUM_LINES-1:0]              clr_o,
   output logic [NUM_LINES-1:0][TRIG_W-1:0]  mode_o
);

   localparam int unsigned PAIRS     = (NUM_LINES + 1) / 2;
   localparam int unsigned PPR       = DATA_W / NIB_W;
   localparam int unsigned TRIG_REGS = (PAIRS + PPR - 1) / PPR;
   localparam int unsigned MASK_ADDR = TRIG_REGS;
   localparam int unsigned PEND_ADDR = TRIG_REGS + 1;
   localparam int unsigned REQ_ADDR  = TRIG_REGS + 2;

   if ((1 << ADDR_W) <= REQ_ADDR) begin : g_bad_addr
      $error("xirq_regs: ADDR_W too narrow for the register map");
   end
   if (NUM_LINES > DATA_W) begin : g_bad_lines
      $error("xirq_regs: NUM_LINES exceeds DATA_W");
   end

   logic [TRIG_W-1:0]    fld_q [PAIRS];
   logic [NUM_LINES-1:0] mask_q;
   logic                 wr_mask;
   logic                 wr_pend;
   logic                 unused_wbits;

   assign wr_mask      = wr_en_i && (addr_i == ADDR_W'(MASK_ADDR));
   assign wr_pend      = wr_en_i && (addr_i == ADDR_W'(PEND_ADDR));
   assign unused_wbits = ^wdata_i;

   for (genvar p = 0; p < PAIRS; p++) begin : g_fld
      localparam int unsigned REG = p / PPR;
      localparam int unsigned LSB = (p % PPR) * NIB_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld_q[p] <= '0;
         else if (wr_en_i && (addr_i == ADDR_W'(REG)))
            fld_q[p] <= wdata_i[LSB +: TRIG_W];
      end
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_mode
      assign mode_o[n] = fld_q[n/2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q <= '1;
      else if (wr_mask)  mask_q <= wdata_i[NUM_LINES-1:0];
   end

   assign mask_o = mask_q;
   assign clr_o  = wr_pend ? wdata_i[NUM_LINES-1:0] : '0;

   always_comb begin
      rdata_o = '0;
      for (int p = 0; p < PAIRS; p++) begin
         if (addr_i == ADDR_W'(p / PPR))
            rdata_o[(p % PPR) * NIB_W +: TRIG_W] = fld_q[p];
      end
      if (addr_i == ADDR_W'(MASK_ADDR)) rdata_o[NUM_LINES-1:0] = mask_q;
      if (addr_i == ADDR_W'(PEND_ADDR)) rdata_o[NUM_LINES-1:0] = pend_i;
      if (addr_i == ADDR_W'(REQ_ADDR))  rdata_o[NUM_LINES-1:0] = pend_i & ~mask_q;
   end

   // R9
   mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (mask_q == $past(wdata_i[NUM_LINES-1:0])));

endmodule

// File: rtl/xirq_grp_or.sv
module xirq_grp_or #(
   parameter int unsigned NUM_LINES = 28,
   parameter int unsigned LO        = 0,
   parameter int unsigned HI        = 4
) (
   input  logic [NUM_LINES-1:0] req_i,
   output logic                 any_o
);

   if (!(LO < HI && HI <= NUM_LINES)) begin : g_bad_range
      $error("xirq_grp_or: group range is empty or out of bounds");
   end

   always_comb begin
      any_o = 1'b0;
      for (int i = LO; i < HI; i++) any_o = any_o | req_i[i];
   end

endmodule

// File: rtl/xirq_line_ctrl.sv
module xirq_line_ctrl
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 28,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GRP1_BASE   = 4,
   parameter int unsigned GRP2_BASE   = 12,
   parameter int unsigned GRP3_BASE   = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   input  logic                 bus_wr_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic [DATA_W-1:0]    bus_wdata_i,
   output logic [DATA_W-1:0]    bus_rdata_o,
   output logic [3:0]           irq_grp_o
);

   localparam int unsigned NUM_GRP = 4;

   function automatic int unsigned grp_edge(input int unsigned g);
      case (g)
         0:       return 0;
         1:       return GRP1_BASE;
         2:       return GRP2_BASE;
         3:       return GRP3_BASE;
         default: return NUM_LINES;
      endcase
   endfunction

   if (!(GRP1_BASE < GRP2_BASE && GRP2_BASE < GRP3_BASE && GRP3_BASE < NUM_LINES))
   begin : g_bad_grp
      $error("xirq_line_ctrl: group bases must rise and stay below NUM_LINES");
   end

   logic [NUM_LINES-1:0]             pend;
   logic [NUM_LINES-1:0]             mask;
   logic [NUM_LINES-1:0]             clr;
   logic [NUM_LINES-1:0]             req;
   logic [NUM_LINES-1:0][TRIG_W-1:0] mode;

   xirq_regs #(
      .NUM_LINES (NUM_LINES),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .pend_i  (pend),
      .rdata_o (bus_rdata_o),
      .mask_o  (mask),
      .clr_o   (clr),
      .mode_o  (mode)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      xirq_line #(
         .SYNC_STAGES (SYNC_STAGES)
      ) i_line (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_i[n]),
         .mode_i (mode[n]),
         .clr_i  (clr[n]),
         .pend_o (pend[n])
      );
   end

   assign req = pend & ~mask;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      xirq_grp_or #(
         .NUM_LINES (NUM_LINES),
         .LO        (grp_edge(g)),
         .HI        (grp_edge(g + 1))
      ) i_grp (
         .req_i (req),
         .any_o (irq_grp_o[g])
      );
   end

   // R10
   grp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |-> (irq_grp_o == 4'b0000));

   // R9
   grp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_grp_o) |-> (|pend));

endmodule

// File: tb/test_xirq_line_ctrl.sv
module test_xirq_line_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 28;
   localparam logic [2:0] A_TLO = 3'd0, A_THI = 3'd1, A_MSK = 3'd2,
                          A_PND = 3'd3, A_REQ = 3'd4;
   localparam logic [31:0] ALL = 32'h0FFF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] pin = '0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [3:0]    irq_grp;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xirq_line_ctrl i_xirq_line_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_grp_o   (irq_grp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [3:0] grp_of(input int n);
      if (n < 4)       return 4'b0001;
      else if (n < 12) return 4'b0010;
      else if (n < 20) return 4'b0100;
      else             return 4'b1000;
   endfunction

   function automatic logic [31:0] lo_fill(input logic [3:0] nib);
      return {8{nib}};
   endfunction

   function automatic logic [31:0] hi_fill(input logic [3:0] nib);
      return {8'h00, {6{nib}}};
   endfunction

   task automatic set_all(input logic [3:0] nib);
      wr(A_TLO, lo_fill(nib));
      wr(A_THI, hi_fill(nib));
      tick(3);
      wr(A_PND, ALL);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      tick(3);
      // R1 reset state
      rd(A_TLO, d); chk("R1 trig-low", d, 32'h0);
      rd(A_THI, d); chk("R1 trig-high", d, 32'h0);
      rd(A_MSK, d); chk("R1 mask", d, ALL);
      rd(A_PND, d); chk("R1 pending", d, 32'h0);
      rd(A_REQ, d); chk("R1 request", d, 32'h0);
      chk("R1 groups", {28'h0, irq_grp}, 32'h0);
      rst_n = 1'b1;
      tick(1);

      // R2 layout and ignored nibbles
      wr(A_TLO, 32'hFFFF_FFFF); rd(A_TLO, d); chk("R2 bit3 reads zero", d, 32'h7777_7777);
      wr(A_THI, 32'hFFFF_FFFF); rd(A_THI, d); chk("R2 lines 28-31 ignored", d, 32'h0077_7777);
      wr(A_THI, 32'h0003_0000); rd(A_THI, d); chk("R2 pair 12 at nibble 4", d, 32'h0003_0000);
      set_all(4'h4);
      rd(A_TLO, d); chk("R2 rise lo", d, 32'h4444_4444);
      rd(A_PND, d); chk("R7 cleared all", d, 32'h0);
      // R9 upper mask bits
      wr(A_MSK, 32'hFFFF_FFFF); rd(A_MSK, d); chk("R9 mask bits 28-31", d, ALL);
      wr(A_MSK, 32'h0);

      // R3 rising sweep, R10 groups, R11 request
      for (int n = 0; n < NL; n++) begin
         pin[n] = 1'b1;
         tick(2); rd(A_PND, d); chk("R3 not before edge k+2", d, 32'h0);
         tick(1); rd(A_PND, d); chk("R3 rise sets", d, 32'h1 << n);
         chk("R10 group", {28'h0, irq_grp}, {28'h0, grp_of(n)});
         rd(A_REQ, d); chk("R11 request", d, 32'h1 << n);
         pin[n] = 1'b0;
         tick(3); rd(A_PND, d); chk("R3 fall ignored", d, 32'h1 << n);
         wr(A_PND, 32'h1 << n); rd(A_PND, d); chk("R7 clear", d, 32'h0);
      end

      // R4 falling sweep
      set_all(4'h2);
      for (int n = 0; n < NL; n++) begin
         pin[n] = 1'b1;
         tick(3); rd(A_PND, d); chk("R4 rise ignored", d, 32'h0);
         pin[n] = 1'b0;
         tick(3); rd(A_PND, d); chk("R4 fall sets", d, 32'h1 << n);
         wr(A_PND, 32'h1 << n);
      end

      // R5 both edges sweep
      set_all(4'h6);
      for (int n = 0; n < NL; n++) begin
         pin[n] = 1'b1;
         tick(3); rd(A_PND, d); chk("R5 rise sets", d, 32'h1 << n);
         wr(A_PND, 32'h1 << n);
         pin[n] = 1'b0;
         tick(3); rd(A_PND, d); chk("R5 fall sets", d, 32'h1 << n);
         wr(A_PND, 32'h1 << n);
      end

      // R6 high level on pair 2 (lines 4,5)
      set_all(4'h4);
      wr(A_TLO, 32'h4444_4144);
      pin[5] = 1'b1;
      tick(3); rd(A_PND, d); chk("R6 high level sets", d, 32'h1 << 5);
      wr(A_PND, 32'h1 << 5); rd(A_PND, d); chk("R8 set beats clear", d, 32'h1 << 5);
      pin[5] = 1'b0;
      tick(3); rd(A_PND, d); chk("R6 latched after level ends", d, 32'h1 << 5);
      wr(A_PND, 32'h1 << 5); rd(A_PND, d); chk("R6 clear sticks", d, 32'h0);
      wr(A_TLO, 32'h4444_4444);

      // R6 low level on pair 13 (lines 26,27); pins low
      wr(A_THI, 32'h0004_4444);
      tick(1); rd(A_PND, d); chk("R6 low level sets", d & 32'h0C00_0000, 32'h0C00_0000);
      wr(A_PND, 32'h0C00_0000); rd(A_PND, d); chk("R8 low level re-sets", d & 32'h0C00_0000, 32'h0C00_0000);
      pin[26] = 1'b1; pin[27] = 1'b1;
      tick(3);
      wr(A_PND, 32'h0C00_0000); rd(A_PND, d); chk("R6 low clear sticks", d, 32'h0);
      wr(A_THI, hi_fill(4'h4));
      tick(3);
      pin[26] = 1'b0; pin[27] = 1'b0;
      tick(3); wr(A_PND, ALL);

      // R9 masked line still latches
      wr(A_MSK, ALL);
      pin[9] = 1'b1;
      tick(3); rd(A_PND, d); chk("R9 masked latches", d, 32'h1 << 9);
      chk("R9 masked group quiet", {28'h0, irq_grp}, 32'h0);
      rd(A_REQ, d); chk("R11 masked request", d, 32'h0);
      wr(A_MSK, ALL & ~(32'h1 << 9));
      chk("R10 unmask group 1", {28'h0, irq_grp}, 32'h2);
      pin[9] = 1'b0;
      wr(A_PND, 32'h1 << 9);

      // R10 multi-line and R7 zero bits preserved
      wr(A_MSK, 32'h0);
      pin[0] = 1'b1; pin[4] = 1'b1; pin[12] = 1'b1; pin[20] = 1'b1;
      tick(3); chk("R10 all groups", {28'h0, irq_grp}, 32'hF);
      wr(A_MSK, 32'h1 << 12); chk("R10 mask line 12", {28'h0, irq_grp}, 32'hB);
      rd(A_REQ, d); chk("R11 request multi", d, 32'h0010_0011);
      wr(A_PND, 32'h1); rd(A_PND, d); chk("R7 zeros keep", d, 32'h0010_1010);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule